// File: doc/BRIEF.md
# Two-Wire Serial Register Access Slave

This block is a two-wire (I2C) serial slave. Through it, a bus master reads and writes a file of twenty byte-wide registers at word addresses 00h to 13h. A faster system clock samples SCL and SDA. The block finds START, repeated START and STOP conditions and answers to the fixed 7-bit device address 1101000. It acknowledges bytes by pulling SDA low and keeps a word pointer that advances by itself. The register file sits outside the block. The block gives it a pointer, a one-cycle write strobe with the write data, and a read data input that it samples combinationally.

The block also drives a freeze signal. While a transaction addressed to this slave is open and the pointer lies in 00h to 07h, the freeze signal tells the timekeeping logic to stop copying its running counters into the readable bytes, so a multi-byte read returns one coherent time. The freeze ends on STOP or as soon as the pointer moves to 08h or higher. The SDA pad is represented only by an output enable that pulls the line low. The block does not stretch the clock.

The protocol controller is a single state machine with these states:
- ST_IDLE waits for a START.
- ST_ADDR shifts in the device address and direction bit. A match leads to ST_ADDR_ACK; a mismatch returns to ST_IDLE.
- From ST_ADDR_ACK, a write goes to ST_WORD and a read goes to ST_RDATA.
- ST_WORD takes in the word address and then moves to ST_WORD_ACK, which leads to ST_WDATA.
- ST_WDATA and ST_WDATA_ACK alternate for every byte written.
- ST_RDATA shifts a byte out and moves to ST_RDATA_ACK. A master ACK there returns to ST_RDATA; a NACK returns to ST_IDLE.
- From any state, STOP forces ST_IDLE and START forces ST_ADDR.

Top module: `i2creg_slave`

## Requirements
- R1: An address byte whose upper seven bits equal 1101000 (D0h write, D1h read) is acknowledged: SDA is held low during the ninth clock. Any other address gets no acknowledge, and the slave ignores all bus traffic until the next START.
- R2: STOP (SDA rising while SCL is high) returns the slave to idle. A repeated START (SDA falling while SCL is high) begins a new address phase at once, and the word pointer keeps its value.
- R3: The SDA pull-down enable changes only while SCL is low.
- R4: In a write, the first byte after the address loads the word pointer. A value above 13h loads 00h.
- R5: Each later data byte of a write is acknowledged and produces exactly one single-cycle pulse of reg_wr_o, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte.
- R6: The pointer advances by one on the acknowledge clock of every data byte, in reads and in writes. From 13h it wraps to 00h.
- R7: In a read, the byte at the pointer is sent MSB first, and sending goes on while the master acknowledges. After a master NACK the slave releases SDA and drives nothing until a new START.
- R8: A read that is not preceded by a word address starts at the pointer value left by the previous transaction.
- R9: freeze_o is high only while a transaction addressed to this slave is open and the pointer is in 00h to 07h. It falls after STOP, and it falls when the pointer reaches 08h.
- R10: Locations 10h to 12h are reserved. A write there is acknowledged but produces no reg_wr_o pulse, and a read there returns 00h whatever reg_rdata_i holds.
- R11: After reset the SDA enable is off, the pointer is 00h, freeze_o is low and reg_wr_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| reg_addr_o | output | PTR_W | Word pointer / register index |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |
| freeze_o | output | 1 | Hold the readable time copy |

## Verification
The bench drives the slave with several traffic patterns:
- a wrong device address followed by extra bytes, which separates a slave that really ignores foreign traffic from one that half-decodes it;
- write bursts that start mid-file, cross the reserved locations and wrap past 13h, which show whether the pointer steps once per acknowledge clock and whether reserved writes are blocked;
- a combined read with a repeated START, a current-address read and a read after an out-of-range word address, which tell apart loading the pointer, keeping it across transactions and forcing it to 00h;
- a repeated START to a foreign address.

freeze_o is checked at points where the pointer has just been loaded, has just crossed 07h, or the bus has just stopped. On every clock the bench checks that the SDA enable never changes while SCL is high.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } bus_state_e;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2creg_sampler.sv
module i2creg_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_sh[SYNC_STAGES-1];
            sda_q  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[SYNC_STAGES-1];
    assign sda_lvl   = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2creg_pointer.sv
module i2creg_pointer #(
    parameter int NREGS      = 20,
    parameter int PTR_W      = 5,
    parameter int FROZEN_TOP = 7,
    parameter int RSV_LO     = 16,
    parameter int RSV_HI     = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       load_val,
    input  logic             step,
    input  logic             sess_on,
    input  logic             sess_off,
    output logic [PTR_W-1:0] ptr,
    output logic             freeze,
    output logic             reserved
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NREGS - 1);

    logic session;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= (int'(load_val) < NREGS) ? load_val[PTR_W-1:0] : '0;
        end else if (step) begin
            ptr <= (ptr == LAST_IDX) ? '0 : ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            session <= 1'b0;
        end else if (sess_off) begin
            session <= 1'b0;
        end else if (sess_on) begin
            session <= 1'b1;
        end
    end

    assign freeze   = session && (int'(ptr) <= FROZEN_TOP);
    assign reserved = (int'(ptr) >= RSV_LO) && (int'(ptr) <= RSV_HI);

endmodule

// File: rtl/i2creg_slave.sv
module i2creg_slave
    import i2creg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         NREGS       = 20,
    parameter int         PTR_W       = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    output logic [PTR_W-1:0] reg_addr_o,
    output logic             reg_wr_o,
    output logic [7:0]       reg_wdata_o,
    input  logic [7:0]       reg_rdata_i,
    output logic             freeze_o
);

    localparam logic [3:0] FULL_CNT = 4'(BYTE_BITS);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    bus_state_e state, state_nx;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [6:0] tx_sh;
    logic       rd_mode;
    logic       mack;
    logic       ptr_load, ptr_step, sess_on, sess_off;
    logic       reserved;
    logic       byte_done, addr_hit;
    logic [7:0] rd_byte;

    i2creg_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2creg_pointer #(.NREGS(NREGS), .PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load),
        .load_val(rx_sh),
        .step    (ptr_step),
        .sess_on (sess_on),
        .sess_off(sess_off),
        .ptr     (reg_addr_o),
        .freeze  (freeze_o),
        .reserved(reserved)
    );

    assign byte_done = (bit_cnt == FULL_CNT);
    assign addr_hit  = (rx_sh[7:1] == DEV_ADDR);
    assign rd_byte   = reserved ? 8'h00 : reg_rdata_i;

    assign ptr_load = (state == ST_WORD) && scl_fall && byte_done;
    assign ptr_step = scl_rise && ((state == ST_WDATA_ACK) || (state == ST_RDATA_ACK));
    assign sess_on  = (state == ST_ADDR) && scl_fall && byte_done && addr_hit;
    assign sess_off = stop_det || ((state == ST_ADDR) && scl_fall && byte_done && !addr_hit);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_nx = rd_mode ? ST_RDATA : ST_WORD;
                ST_WORD:      if (scl_fall && byte_done) state_nx = ST_WORD_ACK;
                ST_WORD_ACK:  if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_done) state_nx = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) state_nx = mack ? ST_RDATA : ST_IDLE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            rd_mode     <= 1'b0;
            mack        <= 1'b0;
            sda_oe_o    <= 1'b0;
            reg_wr_o    <= 1'b0;
            reg_wdata_o <= '0;
        end else begin
            reg_wr_o <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
            end else if (scl_rise) begin
                unique case (state)
                    ST_ADDR, ST_WORD, ST_WDATA: begin
                        bit_cnt <= bit_cnt + 4'd1;
                        rx_sh   <= {rx_sh[6:0], sda_lvl};
                    end
                    ST_RDATA:     bit_cnt <= bit_cnt + 4'd1;
                    ST_RDATA_ACK: mack    <= ~sda_lvl;
                    default:      ;
                endcase
            end else if (scl_fall) begin
                unique case (state)
                    ST_ADDR: if (byte_done) begin
                        bit_cnt  <= '0;
                        sda_oe_o <= addr_hit;
                        rd_mode  <= rx_sh[0];
                    end
                    ST_WORD: if (byte_done) begin
                        bit_cnt  <= '0;
                        sda_oe_o <= 1'b1;
                    end
                    ST_WDATA: if (byte_done) begin
                        bit_cnt     <= '0;
                        sda_oe_o    <= 1'b1;
                        reg_wr_o    <= ~reserved;
                        reg_wdata_o <= rx_sh;
                    end
                    ST_ADDR_ACK: begin
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            tx_sh    <= rd_byte[6:0];
                            sda_oe_o <= ~rd_byte[7];
                        end else begin
                            sda_oe_o <= 1'b0;
                        end
                    end
                    ST_WORD_ACK, ST_WDATA_ACK: sda_oe_o <= 1'b0;
                    ST_RDATA: begin
                        if (byte_done) begin
                            bit_cnt  <= '0;
                            sda_oe_o <= 1'b0;
                        end else begin
                            sda_oe_o <= ~tx_sh[6];
                            tx_sh    <= {tx_sh[5:0], 1'b0};
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (mack) begin
                            tx_sh    <= rd_byte[6:0];
                            sda_oe_o <= ~rd_byte[7];
                        end else begin
                            sda_oe_o <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2creg_slave_chk.sv
module i2creg_slave_chk
    import i2creg_pkg::*;
#(
    parameter int NREGS = 20,
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_lvl,
    input logic             stop_det,
    input logic             sda_oe_o,
    input logic             reg_wr_o,
    input logic [PTR_W-1:0] reg_addr_o,
    input logic             freeze_o,
    input bus_state_e       state
);

    // R3
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_lvl));

    // R5
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    // R10
    wr_not_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> (reg_addr_o < PTR_W'(16) || reg_addr_o > PTR_W'(18)));

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(reg_addr_o) < NREGS);

    // R6
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_addr_o) |-> (reg_addr_o == PTR_W'($past(reg_addr_o) + 1'b1))
                                 || (reg_addr_o == '0) || ($past(state) == ST_WORD));

    // R9
    freeze_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_o |-> (reg_addr_o <= PTR_W'(7)));

    // R9
    freeze_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !freeze_o);

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_o);

endmodule

bind i2creg_slave i2creg_slave_chk #(.NREGS(NREGS), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .stop_det  (stop_det),
    .sda_oe_o  (sda_oe_o),
    .reg_wr_o  (reg_wr_o),
    .reg_addr_o(reg_addr_o),
    .freeze_o  (freeze_o),
    .state     (state)
);

// File: tb/i2creg_slave_test.sv
`timescale 1ns/1ps
module i2creg_slave_test;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_oe_o;
    logic [4:0] reg_addr_o;
    logic       reg_wr_o;
    logic [7:0] reg_wdata_o;
    logic [7:0] reg_rdata_i;
    logic       freeze_o;

    logic [7:0] mem [0:19];
    int         wr_addr_q[$];
    int         wr_data_q[$];
    int         checks = 0;
    int         failures = 0;
    int         oe_viol = 0;
    logic       oe_prev = 1'b0;
    logic       ack;
    logic [7:0] rb;

    always #10 clk = ~clk;

    assign sda_bus     = m_sda & ~sda_oe_o;
    assign reg_rdata_i = mem[reg_addr_o];

    i2creg_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe_o),
        .reg_addr_o (reg_addr_o),
        .reg_wr_o   (reg_wr_o),
        .reg_wdata_o(reg_wdata_o),
        .reg_rdata_i(reg_rdata_i),
        .freeze_o   (freeze_o)
    );

    // External register file model and per-clock monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 20; i++) mem[i] <= 8'h40 + 8'(i);
            for (int i = 16; i <= 18; i++) mem[i] <= 8'hA5;
        end else if (reg_wr_o) begin
            mem[reg_addr_o] <= reg_wdata_o;
            wr_addr_q.push_back(int'(reg_addr_o));
            wr_data_q.push_back(int'(reg_wdata_o));
        end
    end

    // R3 per-clock comparison: enable may only move while the bus clock is low
    always @(negedge clk) begin
        if (rst_n && (sda_oe_o != oe_prev) && m_scl) oe_viol++;
        oe_prev = sda_oe_o;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic got_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(Q);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q / 2);
        got_ack = ~sda_bus; tick(Q / 2);
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            m_scl = 1'b1; tick(Q / 2);
            b = {b[6:0], sda_bus}; tick(Q / 2);
            m_scl = 1'b0;
        end
        tick(2);
        m_sda = give_ack ? 1'b0 : 1'b1; tick(Q - 2);
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(2);
        m_sda = 1'b1;
    endtask

    task automatic check_writes(input string tag, input int exp_n, input int a0, input int d0,
                                input int a1, input int d1, input int a2, input int d2);
        int ea [3];
        int ed [3];
        ea = '{a0, a1, a2};
        ed = '{d0, d1, d2};
        check(wr_addr_q.size() == exp_n, {tag, " write count"}, wr_addr_q.size(), exp_n);
        for (int i = 0; i < exp_n && i < wr_addr_q.size(); i++) begin
            check(wr_addr_q[i] == ea[i], {tag, " write addr"}, wr_addr_q[i], ea[i]);
            check(wr_data_q[i] == ed[i], {tag, " write data"}, wr_data_q[i], ed[i]);
        end
        wr_addr_q.delete();
        wr_data_q.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stimulus
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R11 reset state
        check(sda_oe_o == 1'b0, "R11 oe after reset", sda_oe_o, 0);
        check(reg_addr_o == 5'h00, "R11 pointer after reset", reg_addr_o, 0);
        check(freeze_o == 1'b0, "R11 freeze after reset", freeze_o, 0);
        check(reg_wr_o == 1'b0, "R11 wr after reset", reg_wr_o, 0);

        // R1 foreign address: no ack, following bytes ignored
        bus_start();
        send_byte(8'hA0, ack);
        check(ack == 1'b0, "R1 foreign address nacked", ack, 0);
        send_byte(8'h55, ack);
        check(ack == 1'b0, "R1 ignored byte nacked", ack, 0);
        bus_stop();
        check_writes("R1", 0, 0, 0, 0, 0, 0, 0);

        // R4 R5 R9 write burst across 07h
        bus_start();
        send_byte(8'hD0, ack);
        check(ack == 1'b1, "R1 own write address acked", ack, 1);
        send_byte(8'h05, ack);
        check(ack == 1'b1, "R4 word address acked", ack, 1);
        check(reg_addr_o == 5'h05, "R4 pointer loaded", reg_addr_o, 5);
        check(freeze_o == 1'b1, "R9 freeze with pointer 05h", freeze_o, 1);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        check(ack == 1'b1, "R5 data acked", ack, 1);
        check(reg_addr_o == 5'h08, "R6 pointer after three bytes", reg_addr_o, 8);
        check(freeze_o == 1'b0, "R9 freeze released at 08h", freeze_o, 0);
        bus_stop();
        check_writes("R5", 3, 5, 'h11, 6, 'h22, 7, 'h33);

        // R10 write into reserved location
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h0F, ack);
        send_byte(8'h44, ack);
        send_byte(8'h77, ack);
        check(ack == 1'b1, "R10 reserved write acked", ack, 1);
        bus_stop();
        check_writes("R10", 1, 'h0F, 'h44, 0, 0, 0, 0);

        // R6 wrap on write
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h13, ack);
        send_byte(8'h99, ack);
        send_byte(8'h66, ack);
        bus_stop();
        check_writes("R6", 2, 'h13, 'h99, 0, 'h66, 0, 0);

        // R7 R10 R6 combined read with repeated start
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h12, ack);
        bus_rstart();
        send_byte(8'hD1, ack);
        check(ack == 1'b1, "R1 own read address acked", ack, 1);
        recv_byte(1'b1, rb);
        check(rb == 8'h00, "R10 reserved reads 00h", rb, 0);
        recv_byte(1'b1, rb);
        check(rb == 8'h99, "R7 read 13h", rb, 'h99);
        recv_byte(1'b0, rb);
        check(rb == 8'h66, "R6 read wraps to 00h", rb, 'h66);
        tick(Q);
        check(sda_oe_o == 1'b0, "R7 released after nack", sda_oe_o, 0);
        bus_stop();
        check(freeze_o == 1'b0, "R9 freeze low after stop", freeze_o, 0);

        // R8 current-address read
        bus_start();
        send_byte(8'hD1, ack);
        check(freeze_o == 1'b1, "R9 freeze during read at 01h", freeze_o, 1);
        recv_byte(1'b0, rb);
        check(rb == 8'h41, "R8 current address read", rb, 'h41);
        bus_stop();
        check(freeze_o == 1'b0, "R9 freeze low after read stop", freeze_o, 0);

        // R4 out-of-range word address loads 00h
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h1E, ack);
        bus_stop();
        check(reg_addr_o == 5'h00, "R4 out-of-range loads 00h", reg_addr_o, 0);
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(1'b0, rb);
        bus_stop();
        check(rb == 8'h66, "R4 read after out-of-range load", rb, 'h66);

        // R2 repeated start to foreign address keeps pointer
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h03, ack);
        bus_rstart();
        send_byte(8'hA1, ack);
        check(ack == 1'b0, "R2 repeated start foreign nacked", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(1'b0, rb);
        bus_stop();
        check(rb == 8'h43, "R2 pointer kept across repeated start", rb, 'h43);

        check(oe_viol == 0, "R3 enable moved with SCL high", oe_viol, 0);
        check_writes("R2", 0, 0, 0, 0, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule